// File: doc/BRIEF.md
# Debounced GPIO Port with Interrupt Detection

This block is a 32-pin general-purpose I/O port that sits on a simple register bus. Software drives the pins through an output data register, picks per pin whether the block drives the pad, and reads the pin levels back after a two-flop synchronizer. Two write-only registers change individual output bits atomically, so no read-modify-write is needed.

Every pin can raise an interrupt. Detection can be on an edge or on a level. A polarity bit selects a rising edge or a high level, or else a falling edge or a low level. A both-edges bit makes an edge pin respond to either transition. Raw status, masked status, enable, mask and write-one-to-clear registers lead to a single combined interrupt line. Any pin can pass through a debounce filter that is paced by a shared 16-bit prescaler. Pull-up enable and type, and a bypass selection, are only stored and driven to output ports for the pad ring.

Top module: `gpio_irq_top`

## Requirements
- R1: After reset every register reads 0, `pinOut`, `pinOutEn`, the pull and bypass outputs are 0, and `irqOut` is 0.
- R2: Offset 0x00 holds the output data, which drives `pinOut` and reads back. Offset 0x08 holds the direction: a bit of 1 makes the pin an output, and `pinOutEn` equals this register.
- R3: A write to 0x10 sets the output bits written as 1. A write to 0x14 clears the output bits written as 1. Bits written as 0 keep their value in both cases.
- R4: Offset 0x04 returns the pin levels after a two-flop synchronizer. Writes to 0x04 have no effect.
- R5: When the trigger bit (0x34) is 0 and the polarity bit (0x3C) is 0, a rising edge sets that pin's raw bit at 0x24. The bit stays set until a 1 is written to the same bit of 0x30.
- R6: An edge pin with a polarity bit of 1 sets its raw bit on a falling edge only.
- R7: An edge pin whose both-edges bit (0x38) is 1 sets its raw bit on either transition, whatever its polarity bit.
- R8: When the trigger bit is 1, the raw bit follows the input: it is 1 while the pin is high (polarity 0) or low (polarity 1).
- R9: The masked status at 0x28 equals raw AND enable (0x20) AND NOT mask (0x2C), where a mask bit of 1 suppresses the pin. `irqOut` is the OR of the masked status.
- R10: When a pin's debounce bit (0x40) is 1 and the prescale value (0x44, bits 15:0) is nonzero, the pin accepts a new level only after it has stayed stable for a whole prescale period. A pulse shorter than the period is never detected.
- R11: When a pin's debounce bit is 1 and the prescale value is 0, that pin detects no edge and no level.
- R12: Pull enable (0x18), pull type (0x1C) and bypass (0x0C) are stored, read back and driven on `pullEnOut`, `pullTypeOut` and `bypassOut`.
- R13: A read strobe returns its data on `regRdData` with `regRdValid` high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 8 | Byte offset of the register |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, one cycle after the strobe |
| regRdValid | output | 1 | Read data valid |
| pinIn | input | 32 | Pad input levels (asynchronous) |
| pinOut | output | 32 | Pad output data |
| pinOutEn | output | 32 | Pad output enable, 1 = drive |
| pullEnOut | output | 32 | Stored pull-up enable |
| pullTypeOut | output | 32 | Stored pull type |
| bypassOut | output | 32 | Stored bypass selection |
| irqOut | output | 1 | Combined interrupt |

## Verification
The bench targets the points where detection modes interact. It checks that a sticky edge bit outlives its input and clears only through the clear register, so a design that let edge bits follow the pin would lose events. It checks that a falling edge on a rising-polarity pin is ignored and that the both-edges bit overrides polarity, so a swapped polarity decode shows up as a wrong raw word. It sends a short glitch through a debounced pin and expects it to vanish, and with a zero prescale it expects an active-low level on a debounced pin to stay undetected. A filter that passed glitches, or a zero-prescale guard that covered only edges, would set raw bits in those cases.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int PIN_W   = 32;
  localparam int ADDR_W  = 8;
  localparam int PRE_W   = 16;

  localparam logic [ADDR_W-1:0] OFF_DOUT  = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_DIN   = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_DIR   = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_BYP   = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_SET   = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_CLR   = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_PEN   = 8'h18;
  localparam logic [ADDR_W-1:0] OFF_PTYP  = 8'h1C;
  localparam logic [ADDR_W-1:0] OFF_IEN   = 8'h20;
  localparam logic [ADDR_W-1:0] OFF_RAW   = 8'h24;
  localparam logic [ADDR_W-1:0] OFF_MSK   = 8'h28;
  localparam logic [ADDR_W-1:0] OFF_IMASK = 8'h2C;
  localparam logic [ADDR_W-1:0] OFF_ICLR  = 8'h30;
  localparam logic [ADDR_W-1:0] OFF_TRIG  = 8'h34;
  localparam logic [ADDR_W-1:0] OFF_BOTH  = 8'h38;
  localparam logic [ADDR_W-1:0] OFF_POL   = 8'h3C;
  localparam logic [ADDR_W-1:0] OFF_DBEN  = 8'h40;
  localparam logic [ADDR_W-1:0] OFF_PRE   = 8'h44;

  // detection configuration handed from the register file to the datapath
  typedef struct packed {
    logic [PIN_W-1:0] dbEn;
    logic [PIN_W-1:0] trigLevel;
    logic [PIN_W-1:0] bothEdges;
    logic [PIN_W-1:0] polLow;
    logic [PRE_W-1:0] prescale;
  } det_cfg_t;

  // one-cycle strobes from control to datapath
  typedef struct packed {
    logic             clrStrobe;
    logic [PIN_W-1:0] clrBits;
  } dp_strobe_t;
endpackage

// File: rtl/gpio_irq_datapath.sv
module gpio_irq_datapath
  import gpio_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PIN_W-1:0] pinIn,
  input  det_cfg_t         cfg,
  input  dp_strobe_t       strobe,
  output logic [PIN_W-1:0] pinSync,
  output logic [PIN_W-1:0] rawBits
);
  localparam int LAST_STAGE = SYNC_STAGES - 1;

  // input synchronizer
  logic [PIN_W-1:0] syncStage [SYNC_STAGES];

  always_ff @(posedge clk) begin
    if (!rstN) syncStage[0] <= '0;
    else       syncStage[0] <= pinIn;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk) begin
      if (!rstN) syncStage[s] <= '0;
      else       syncStage[s] <= syncStage[s-1];
    end
  end

  assign pinSync = syncStage[LAST_STAGE];

  // shared prescaler
  logic [PRE_W-1:0] preCnt;
  logic             preTick;
  logic             preZero;

  assign preZero = (cfg.prescale == '0);
  assign preTick = !preZero && (preCnt >= cfg.prescale - PRE_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN || preZero || preTick) preCnt <= '0;
    else                             preCnt <= preCnt + PRE_W'(1);
  end

  // per-pin stability filter
  logic [PIN_W-1:0] candQ, glitchQ, filtQ, glitchNow;

  assign glitchNow = glitchQ | (pinSync ^ candQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      candQ   <= '0;
      glitchQ <= '0;
      filtQ   <= '0;
    end else begin
      candQ <= pinSync;
      if (preTick) begin
        glitchQ <= '0;
        filtQ   <= (filtQ & glitchNow) | (pinSync & ~glitchNow);
      end else begin
        glitchQ <= glitchNow;
      end
    end
  end

  // detection
  logic [PIN_W-1:0] level, prevLevel, rise, fall, edgeHit, lvlHit, blocked, clrMask;

  assign level   = (cfg.dbEn & filtQ) | (~cfg.dbEn & pinSync);
  assign blocked = cfg.dbEn & {PIN_W{preZero}};
  assign rise    = level & ~prevLevel;
  assign fall    = ~level & prevLevel;
  assign edgeHit = (cfg.bothEdges & (rise | fall))
                 | (~cfg.bothEdges & ((cfg.polLow & fall) | (~cfg.polLow & rise)));
  assign lvlHit  = level ^ cfg.polLow;
  assign clrMask = strobe.clrStrobe ? strobe.clrBits : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevLevel <= '0;
      rawBits   <= '0;
    end else begin
      prevLevel <= level;
      rawBits   <= (cfg.trigLevel & lvlHit & ~blocked)
                 | (~cfg.trigLevel & ((rawBits & ~clrMask) | (edgeHit & ~blocked)));
    end
  end
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [PIN_W-1:0]  regWrData,
  output logic [PIN_W-1:0]  regRdData,
  output logic              regRdValid,
  input  logic [PIN_W-1:0]  pinSync,
  input  logic [PIN_W-1:0]  rawBits,
  output det_cfg_t          cfg,
  output dp_strobe_t        strobe,
  output logic [PIN_W-1:0]  dataOutQ,
  output logic [PIN_W-1:0]  dirQ,
  output logic [PIN_W-1:0]  bypassQ,
  output logic [PIN_W-1:0]  pullEnQ,
  output logic [PIN_W-1:0]  pullTypeQ,
  output logic [PIN_W-1:0]  intEnQ,
  output logic [PIN_W-1:0]  intMaskQ,
  output logic [PIN_W-1:0]  maskedBits
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataOutQ  <= '0;
      dirQ      <= '0;
      bypassQ   <= '0;
      pullEnQ   <= '0;
      pullTypeQ <= '0;
      intEnQ    <= '0;
      intMaskQ  <= '0;
      cfg       <= '0;
    end else if (regWrEn) begin
      case (regAddr)
        OFF_DOUT:  dataOutQ      <= regWrData;
        OFF_SET:   dataOutQ      <= dataOutQ | regWrData;
        OFF_CLR:   dataOutQ      <= dataOutQ & ~regWrData;
        OFF_DIR:   dirQ          <= regWrData;
        OFF_BYP:   bypassQ       <= regWrData;
        OFF_PEN:   pullEnQ       <= regWrData;
        OFF_PTYP:  pullTypeQ     <= regWrData;
        OFF_IEN:   intEnQ        <= regWrData;
        OFF_IMASK: intMaskQ      <= regWrData;
        OFF_TRIG:  cfg.trigLevel <= regWrData;
        OFF_BOTH:  cfg.bothEdges <= regWrData;
        OFF_POL:   cfg.polLow    <= regWrData;
        OFF_DBEN:  cfg.dbEn      <= regWrData;
        OFF_PRE:   cfg.prescale  <= regWrData[PRE_W-1:0];
        default: ;
      endcase
    end
  end

  assign strobe.clrStrobe = regWrEn && (regAddr == OFF_ICLR);
  assign strobe.clrBits   = regWrData;
  assign maskedBits       = rawBits & intEnQ & ~intMaskQ;

  logic [PIN_W-1:0] rdMux;

  always_comb begin
    case (regAddr)
      OFF_DOUT:  rdMux = dataOutQ;
      OFF_DIN:   rdMux = pinSync;
      OFF_DIR:   rdMux = dirQ;
      OFF_BYP:   rdMux = bypassQ;
      OFF_PEN:   rdMux = pullEnQ;
      OFF_PTYP:  rdMux = pullTypeQ;
      OFF_IEN:   rdMux = intEnQ;
      OFF_RAW:   rdMux = rawBits;
      OFF_MSK:   rdMux = maskedBits;
      OFF_IMASK: rdMux = intMaskQ;
      OFF_TRIG:  rdMux = cfg.trigLevel;
      OFF_BOTH:  rdMux = cfg.bothEdges;
      OFF_POL:   rdMux = cfg.polLow;
      OFF_DBEN:  rdMux = cfg.dbEn;
      OFF_PRE:   rdMux = PIN_W'(cfg.prescale);
      default:   rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regRdData  <= '0;
      regRdValid <= 1'b0;
    end else begin
      regRdValid <= regRdEn;
      if (regRdEn) regRdData <= rdMux;
    end
  end
endmodule

// File: rtl/gpio_irq_top.sv
module gpio_irq_top
  import gpio_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [PIN_W-1:0]  regWrData,
  output logic [PIN_W-1:0]  regRdData,
  output logic              regRdValid,
  input  logic [PIN_W-1:0]  pinIn,
  output logic [PIN_W-1:0]  pinOut,
  output logic [PIN_W-1:0]  pinOutEn,
  output logic [PIN_W-1:0]  pullEnOut,
  output logic [PIN_W-1:0]  pullTypeOut,
  output logic [PIN_W-1:0]  bypassOut,
  output logic              irqOut
);
  det_cfg_t         cfg;
  dp_strobe_t       strobe;
  logic [PIN_W-1:0] pinSync, rawBits, intEnQ, intMaskQ, maskedBits;

  gpio_irq_regs u_regs (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .regRdValid(regRdValid),
    .pinSync(pinSync), .rawBits(rawBits), .cfg(cfg), .strobe(strobe),
    .dataOutQ(pinOut), .dirQ(pinOutEn), .bypassQ(bypassOut),
    .pullEnQ(pullEnOut), .pullTypeQ(pullTypeOut),
    .intEnQ(intEnQ), .intMaskQ(intMaskQ), .maskedBits(maskedBits)
  );

  gpio_irq_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .cfg(cfg), .strobe(strobe),
    .pinSync(pinSync), .rawBits(rawBits)
  );

  assign irqOut = |maskedBits;
endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk
  import gpio_irq_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic              regRdEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [PIN_W-1:0]  regWrData,
  input logic              regRdValid,
  input logic [PIN_W-1:0]  pinOut,
  input logic [PIN_W-1:0]  pinOutEn,
  input logic              irqOut,
  input logic [PIN_W-1:0]  rawBits,
  input logic [PIN_W-1:0]  intMaskQ,
  input det_cfg_t          cfg
);
  logic [PIN_W-1:0] blk;
  assign blk = cfg.dbEn & {PIN_W{cfg.prescale == '0}};

  a_r3_set_bits: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == OFF_SET) |=> ((pinOut & $past(regWrData)) == $past(regWrData)));

  a_r3_clr_bits: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == OFF_CLR) |=> ((pinOut & $past(regWrData)) == '0));

  a_r2_dir_drives_oe: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == OFF_DIR) |=> (pinOutEn == $past(regWrData)));

  a_r11_blocked_quiet: assert property (@(posedge clk) disable iff (!rstN)
    ((blk & $past(blk) & rawBits & ~$past(rawBits)) == '0));

  a_r13_read_valid: assert property (@(posedge clk) disable iff (!rstN)
    regRdEn |=> regRdValid);

  a_r13_no_spurious_valid: assert property (@(posedge clk) disable iff (!rstN)
    !regRdEn |=> !regRdValid);

  a_r9_all_masked_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (intMaskQ == '1) |-> !irqOut);
endmodule

bind gpio_irq_top gpio_irq_chk u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
  .regAddr(regAddr), .regWrData(regWrData), .regRdValid(regRdValid),
  .pinOut(pinOut), .pinOutEn(pinOutEn), .irqOut(irqOut),
  .rawBits(rawBits), .intMaskQ(intMaskQ), .cfg(cfg)
);

// File: tb/tb_gpio_irq_top.sv
module tb_gpio_irq_top;
  import gpio_irq_pkg::*;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              regWrEn = 1'b0;
  logic              regRdEn = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic [PIN_W-1:0]  regWrData = '0;
  logic [PIN_W-1:0]  regRdData;
  logic              regRdValid;
  logic [PIN_W-1:0]  pinIn = '0;
  logic [PIN_W-1:0]  pinOut, pinOutEn, pullEnOut, pullTypeOut, bypassOut;
  logic              irqOut;

  int checks = 0;
  int fails  = 0;
  logic [PIN_W-1:0] expQ[$];
  string            tagQ[$];

  always #5 clk = ~clk;

  gpio_irq_top dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .regRdValid(regRdValid), .pinIn(pinIn), .pinOut(pinOut),
    .pinOutEn(pinOutEn), .pullEnOut(pullEnOut), .pullTypeOut(pullTypeOut),
    .bypassOut(bypassOut), .irqOut(irqOut)
  );

  task automatic check(input string tag, input logic [PIN_W-1:0] act, input logic [PIN_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data as results appear
  always @(negedge clk) begin
    if (regRdValid) begin
      if (expQ.size() == 0) check("R13 unexpected read data", 32'h1, 32'h0);
      else check(tagQ.pop_front(), regRdData, expQ.pop_front());
    end
  end

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [PIN_W-1:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  // driver: pushes the expected item, then issues the read
  task automatic rd(input logic [ADDR_W-1:0] a, input logic [PIN_W-1:0] exp, input string tag);
    @(negedge clk);
    expQ.push_back(exp); tagQ.push_back(tag);
    regRdEn = 1'b1; regAddr = a;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check("watchdog expired", 32'h1, 32'h0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(1);
    // R1 reset state
    check("R1 pinOut", pinOut, '0);
    check("R1 pinOutEn", pinOutEn, '0);
    check("R1 irqOut", {31'b0, irqOut}, '0);
    check("R1 valid idle", {31'b0, regRdValid}, '0);
    rd(OFF_DOUT, '0, "R1 dout");
    rd(OFF_RAW,  '0, "R1 raw");
    rd(OFF_PRE,  '0, "R1 prescale");

    // R2 output data and direction
    wr(OFF_DOUT, 32'hA5A5_0F0F);
    rd(OFF_DOUT, 32'hA5A5_0F0F, "R2 dout readback");
    check("R2 pinOut", pinOut, 32'hA5A5_0F0F);
    wr(OFF_DIR, 32'hFFFF_0000);
    check("R2 pinOutEn", pinOutEn, 32'hFFFF_0000);

    // R3 atomic set/clear
    wr(OFF_SET, 32'h0000_00F0);
    check("R3 set", pinOut, 32'hA5A5_0FFF);
    wr(OFF_CLR, 32'h0F00_0000);
    check("R3 clear", pinOut, 32'hA0A5_0FFF);
    rd(OFF_DOUT, 32'hA0A5_0FFF, "R3 readback");

    // R4 data in, read-only
    pinIn = 32'h1234_5678;
    waitCyc(5);
    rd(OFF_DIN, 32'h1234_5678, "R4 din");
    wr(OFF_DIN, 32'h0);
    rd(OFF_DIN, 32'h1234_5678, "R4 din write ignored");

    // R5 rising edge, sticky, write-one clear
    pinIn = '0;
    wr(OFF_IEN, '1);
    waitCyc(5);
    wr(OFF_ICLR, '1);
    rd(OFF_RAW, '0, "R5 cleared start");
    pinIn[0] = 1'b1; waitCyc(5);
    rd(OFF_RAW, 32'h1, "R5 rise sets");
    check("R5 irq", {31'b0, irqOut}, 32'h1);
    pinIn[0] = 1'b0; waitCyc(5);
    rd(OFF_RAW, 32'h1, "R5 sticky");
    wr(OFF_ICLR, 32'h1);
    rd(OFF_RAW, '0, "R5 clear");
    check("R5 irq low", {31'b0, irqOut}, '0);

    // R6 falling edge
    wr(OFF_POL, 32'h2);
    pinIn[1] = 1'b1; waitCyc(5);
    rd(OFF_RAW, '0, "R6 rise ignored");
    pinIn[1] = 1'b0; waitCyc(5);
    rd(OFF_RAW, 32'h2, "R6 fall sets");
    wr(OFF_ICLR, '1);

    // R7 both edges
    wr(OFF_BOTH, 32'h4);
    pinIn[2] = 1'b1; waitCyc(5);
    rd(OFF_RAW, 32'h4, "R7 rise");
    wr(OFF_ICLR, 32'h4);
    pinIn[2] = 1'b0; waitCyc(5);
    rd(OFF_RAW, 32'h4, "R7 fall");
    wr(OFF_ICLR, '1);

    // R8 level, both polarities
    wr(OFF_TRIG, 32'h18);
    wr(OFF_POL, 32'h12);
    waitCyc(2);
    rd(OFF_RAW, 32'h10, "R8 active-low");
    pinIn[3] = 1'b1; waitCyc(5);
    rd(OFF_RAW, 32'h18, "R8 active-high");
    pinIn[3] = 1'b0; pinIn[4] = 1'b1; waitCyc(5);
    rd(OFF_RAW, '0, "R8 follows input");

    // R9 masked state and irq
    pinIn[4] = 1'b0; waitCyc(5);
    wr(OFF_IMASK, 32'h10);
    rd(OFF_MSK, '0, "R9 masked");
    check("R9 irq masked", {31'b0, irqOut}, '0);
    wr(OFF_IMASK, '0);
    rd(OFF_MSK, 32'h10, "R9 unmasked");
    check("R9 irq", {31'b0, irqOut}, 32'h1);
    wr(OFF_IEN, ~32'h10);
    rd(OFF_MSK, '0, "R9 disabled");
    check("R9 irq disabled", {31'b0, irqOut}, '0);
    wr(OFF_IEN, '1);
    pinIn[4] = 1'b1; waitCyc(5);

    // R10 debounce
    wr(OFF_TRIG, '0);
    wr(OFF_POL, '0);
    wr(OFF_DBEN, 32'h20);
    wr(OFF_PRE, 32'h8);
    wr(OFF_ICLR, '1);
    waitCyc(20);
    pinIn[5] = 1'b1; waitCyc(2); pinIn[5] = 1'b0;
    waitCyc(40);
    rd(OFF_RAW, '0, "R10 glitch rejected");
    pinIn[5] = 1'b1;
    waitCyc(40);
    rd(OFF_RAW, 32'h20, "R10 stable accepted");

    // R11 zero prescale blocks detection
    wr(OFF_PRE, 32'h0);
    wr(OFF_DBEN, 32'h60);
    wr(OFF_ICLR, '1);
    pinIn[6] = 1'b1; waitCyc(40);
    rd(OFF_RAW, '0, "R11 edge blocked");
    wr(OFF_TRIG, 32'h40);
    wr(OFF_POL, 32'h40);
    waitCyc(5);
    rd(OFF_RAW, '0, "R11 level blocked");

    // R12 stored pad settings
    wr(OFF_PEN, 32'hDEAD_0001);
    wr(OFF_PTYP, 32'h0000_BEEF);
    wr(OFF_BYP, 32'h8000_0002);
    check("R12 pullEnOut", pullEnOut, 32'hDEAD_0001);
    check("R12 pullTypeOut", pullTypeOut, 32'h0000_BEEF);
    check("R12 bypassOut", bypassOut, 32'h8000_0002);
    rd(OFF_PTYP, 32'h0000_BEEF, "R12 readback");

    // R13 every issued read produced one result
    waitCyc(3);
    check("R13 queue drained", expQ.size(), '0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule